// File: doc/BRIEF.md
# Banked Register Read-Port Arbiter with Round-Robin Write-Bank Allocator

This block sits at the in-order end of a pipeline that uses value prediction. It serves a register file split into banks, each with a small fixed set of read ports. Those ports are shared between two consumers. Validation reads the predicted destination value of a committing instruction. Late execution reads the two source operands of a simple predicted instruction just before it retires. Each cycle the arbiter looks at a group of up to eight committing instructions, oldest first. Each instruction carries a kind and the bank of every operand it might read. The arbiter grants the longest in-order run whose combined reads fit every bank's port budget, and it tells each bank port which slot and which operand it serves.

A companion allocator decides where predicted results are written. Predictions arriving in one cycle are spread over consecutive banks, starting from a next-bank pointer. The pointer then moves on by the number of predictions written. An in-order group therefore lands evenly across the banks, and each bank needs only a couple of write ports.

All outputs are registered, so results appear one clock after the inputs are presented. Reset is synchronous and active high.

Top module: `bank_rdport_arb`

## Requirements
- R1: After reset, `grant_cnt` is 0, every `port_en` bit is 0, every `wr_en` bit is 0, and the next-bank pointer is bank 0, so the first prediction after reset is written to bank 0.
- R2: A slot's 2-bit kind sets its reads. Kind 0 needs no read. Kind 1 (validate) reads the destination bank once. Kind 2 (late execute) reads the source-0 bank and the source-1 bank. Kind 3 (late execute and validate) reads source 0, source 1 and destination.
- R3: `grant_cnt` equals the length of the longest prefix of slots, starting at slot 0, in which every slot is valid and the cumulative reads of each bank are at most `RD_PORTS`. The first invalid slot ends the prefix.
- R4: The first valid slot whose reads would exceed any bank's remaining ports ends the grant. Younger slots are not granted in that cycle, even if they would fit.
- R5: Within a bank, granted reads take port 0 upward, in program order, and within a slot in the order source 0, source 1, destination. For each enabled port, `port_slot` gives the slot index and `port_opnd` gives the operand (0 source 0, 1 source 1, 2 destination). Unused ports have `port_en` low.
- R6: A slot that reads two operands in the same bank takes two distinct ports of that bank.
- R7: No port serves more than one read in a cycle. The enabled ports of each bank form a contiguous run from port 0, and the total number of enabled ports equals the total reads of the granted slots.
- R8: Grant, port and write outputs change only at a clock edge. They reflect the inputs sampled at the previous edge.
- R9: With `pred_cnt` = n (values above `GROUP_W` treated as `GROUP_W`), `wr_en` bits 0 to n-1 are set and all others are clear.
- R10: Prediction j is assigned bank (P + j) mod `NUM_BANKS`, where P is the next-bank pointer. P then advances by the clamped prediction count, modulo `NUM_BANKS`.
- R11: Slots of kind 0 (stores and loads on this path) are granted without using any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | GROUP_W | Per-slot valid, slot 0 oldest |
| slot_kind | input | 2*GROUP_W | Per-slot read kind (R2 encoding) |
| slot_src0_bank | input | GROUP_W*BW | Bank of source operand 0 per slot |
| slot_src1_bank | input | GROUP_W*BW | Bank of source operand 1 per slot |
| slot_dst_bank | input | GROUP_W*BW | Bank of predicted destination per slot |
| pred_cnt | input | CW | Number of predictions to place this cycle |
| grant_cnt | output | CW | Number of slots granted, in program order |
| port_en | output | NUM_BANKS*RD_PORTS | Port enable, index bank*RD_PORTS+port |
| port_slot | output | NUM_BANKS*RD_PORTS*SW | Slot served by each port |
| port_opnd | output | NUM_BANKS*RD_PORTS*2 | Operand served by each port |
| wr_en | output | GROUP_W | Prediction write enable per prediction index |
| wr_bank | output | GROUP_W*BW | Bank assigned to each prediction index |

## Verification
Every result of this block is due exactly one rising edge after its inputs are applied. The bench drives each stimulus on a falling edge, lets one rising edge capture it, and compares on the following falling edge. The expected values come from a bench model that walks the slots in program order and tracks its own next-bank pointer. Just after each new stimulus is driven, and before the next rising edge, the bench also confirms that `grant_cnt` still holds the previous result. This shows that nothing leaks through combinationally.

// File: rtl/rdarb_pkg.sv
package rdarb_pkg;

    // Read kind of a committing slot; bit 1 = late execute, bit 0 = validate.
    typedef enum logic [1:0] {
        RK_NONE       = 2'd0,
        RK_CHECK      = 2'd1,
        RK_LATE       = 2'd2,
        RK_LATE_CHECK = 2'd3
    } rd_kind_e;

    // Operand served by a bank port.
    typedef enum logic [1:0] {
        OP_SRC0 = 2'd0,
        OP_SRC1 = 2'd1,
        OP_DST  = 2'd2
    } rd_opnd_e;

    localparam int OPS_PER_SLOT = 3;

endpackage

// File: rtl/rdarb_demand.sv
module rdarb_demand
    import rdarb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic [1:0]                  kind,
    input  logic [BW-1:0]               src0_bank,
    input  logic [BW-1:0]               src1_bank,
    input  logic [BW-1:0]               dst_bank,
    output logic [OPS_PER_SLOT-1:0]     op_use,
    output logic [OPS_PER_SLOT*BW-1:0]  op_bank,
    output logic [NUM_BANKS*2-1:0]      need
);

    // Which operands this slot reads (R2).
    always_comb begin
        unique case (rd_kind_e'(kind))
            RK_NONE:       op_use = 3'b000;
            RK_CHECK:      op_use = 3'b100;
            RK_LATE:       op_use = 3'b011;
            RK_LATE_CHECK: op_use = 3'b111;
        endcase
    end

    assign op_bank = {dst_bank, src1_bank, src0_bank};

    // Reads requested from each bank.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic [1:0] cnt;
            cnt = 2'd0;
            for (int k = 0; k < OPS_PER_SLOT; k++) begin
                if (op_use[k] && (op_bank[k*BW +: BW] == BW'(b)))
                    cnt = cnt + 2'd1;
            end
            need[b*2 +: 2] = cnt;
        end
    end

endmodule

// File: rtl/rdarb_grant.sv
module rdarb_grant
    import rdarb_pkg::*;
#(
    parameter int GROUP_W   = 8,
    parameter int NUM_BANKS = 4,
    parameter int RD_PORTS  = 4,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int SW = $clog2(GROUP_W),
    localparam int CW = $clog2(GROUP_W + 1),
    localparam int NP = NUM_BANKS * RD_PORTS
) (
    input  logic [GROUP_W-1:0]                 slot_valid,
    input  logic [GROUP_W*OPS_PER_SLOT-1:0]    op_use,
    input  logic [GROUP_W*OPS_PER_SLOT*BW-1:0] op_bank,
    input  logic [GROUP_W*NUM_BANKS*2-1:0]     need,
    output logic [CW-1:0]                      gcnt,
    output logic [NP-1:0]                      pen,
    output logic [NP*SW-1:0]                   pslot,
    output logic [NP*2-1:0]                    popnd
);

    localparam int UW = $clog2(RD_PORTS + 4) + 1;

    logic [UW-1:0] used [NUM_BANKS];
    logic          stop;
    logic          fit;
    logic [BW-1:0] bk;
    int            idx;

    // Serial in-order walk: each slot either fits in what is left, or stops
    // the grant for all younger slots (R3, R4). Ports fill from 0 up (R5).
    always_comb begin
        pen   = '0;
        pslot = '0;
        popnd = '0;
        gcnt  = '0;
        stop  = 1'b0;
        fit   = 1'b0;
        bk    = '0;
        idx   = 0;
        for (int b = 0; b < NUM_BANKS; b++) used[b] = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            fit = 1'b1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(used[b]) + int'(need[(i*NUM_BANKS + b)*2 +: 2]) > RD_PORTS)
                    fit = 1'b0;
            end
            if (!stop && slot_valid[i] && fit) begin
                for (int k = 0; k < OPS_PER_SLOT; k++) begin
                    if (op_use[i*OPS_PER_SLOT + k]) begin
                        bk  = op_bank[(i*OPS_PER_SLOT + k)*BW +: BW];
                        idx = int'(bk) * RD_PORTS + int'(used[bk]);
                        pen[idx]             = 1'b1;
                        pslot[idx*SW +: SW]  = SW'(i);
                        popnd[idx*2 +: 2]    = 2'(k);
                        used[bk]             = used[bk] + UW'(1);
                    end
                end
                gcnt = gcnt + CW'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rdarb_wbank.sv
module rdarb_wbank #(
    parameter int GROUP_W   = 8,
    parameter int NUM_BANKS = 4,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int CW = $clog2(GROUP_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CW-1:0]           pred_cnt,
    output logic [GROUP_W-1:0]      wr_en,
    output logic [GROUP_W*BW-1:0]   wr_bank
);

    logic [BW-1:0]         nxt_bank_q;
    logic [BW-1:0]         nxt_bank_d;
    logic [CW-1:0]         cnt_c;
    logic [GROUP_W-1:0]    en_c;
    logic [GROUP_W*BW-1:0] bank_c;

    // Clamp, enable mask, consecutive banks from the pointer (R9, R10).
    always_comb begin
        cnt_c = (pred_cnt > CW'(GROUP_W)) ? CW'(GROUP_W) : pred_cnt;
        for (int j = 0; j < GROUP_W; j++) begin
            en_c[j]            = (CW'(j) < cnt_c);
            bank_c[j*BW +: BW] = nxt_bank_q + BW'(j);
        end
        nxt_bank_d = nxt_bank_q + BW'(cnt_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_bank_q <= '0;
            wr_en      <= '0;
            for (int j = 0; j < GROUP_W; j++) wr_bank[j*BW +: BW] <= BW'(j);
        end else begin
            nxt_bank_q <= nxt_bank_d;
            wr_en      <= en_c;
            wr_bank    <= bank_c;
        end
    end

endmodule

// File: rtl/bank_rdport_arb.sv
module bank_rdport_arb
    import rdarb_pkg::*;
#(
    parameter int GROUP_W   = 8,
    parameter int NUM_BANKS = 4,
    parameter int RD_PORTS  = 4,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int SW = $clog2(GROUP_W),
    localparam int CW = $clog2(GROUP_W + 1),
    localparam int NP = NUM_BANKS * RD_PORTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [GROUP_W-1:0]      slot_valid,
    input  logic [2*GROUP_W-1:0]    slot_kind,
    input  logic [GROUP_W*BW-1:0]   slot_src0_bank,
    input  logic [GROUP_W*BW-1:0]   slot_src1_bank,
    input  logic [GROUP_W*BW-1:0]   slot_dst_bank,
    input  logic [CW-1:0]           pred_cnt,
    output logic [CW-1:0]           grant_cnt,
    output logic [NP-1:0]           port_en,
    output logic [NP*SW-1:0]        port_slot,
    output logic [NP*2-1:0]         port_opnd,
    output logic [GROUP_W-1:0]      wr_en,
    output logic [GROUP_W*BW-1:0]   wr_bank
);

    logic [GROUP_W*OPS_PER_SLOT-1:0]    op_use;
    logic [GROUP_W*OPS_PER_SLOT*BW-1:0] op_bank;
    logic [GROUP_W*NUM_BANKS*2-1:0]     need;
    logic [CW-1:0]                      gcnt_c;
    logic [NP-1:0]                      pen_c;
    logic [NP*SW-1:0]                   pslot_c;
    logic [NP*2-1:0]                    popnd_c;

    for (genvar i = 0; i < GROUP_W; i++) begin : g_slot
        rdarb_demand #(.NUM_BANKS(NUM_BANKS)) demand_i (
            .kind      (slot_kind[2*i +: 2]),
            .src0_bank (slot_src0_bank[i*BW +: BW]),
            .src1_bank (slot_src1_bank[i*BW +: BW]),
            .dst_bank  (slot_dst_bank[i*BW +: BW]),
            .op_use    (op_use[i*OPS_PER_SLOT +: OPS_PER_SLOT]),
            .op_bank   (op_bank[i*OPS_PER_SLOT*BW +: OPS_PER_SLOT*BW]),
            .need      (need[i*NUM_BANKS*2 +: NUM_BANKS*2])
        );
    end

    rdarb_grant #(
        .GROUP_W   (GROUP_W),
        .NUM_BANKS (NUM_BANKS),
        .RD_PORTS  (RD_PORTS)
    ) grant_i (
        .slot_valid (slot_valid),
        .op_use     (op_use),
        .op_bank    (op_bank),
        .need       (need),
        .gcnt       (gcnt_c),
        .pen        (pen_c),
        .pslot      (pslot_c),
        .popnd      (popnd_c)
    );

    rdarb_wbank #(
        .GROUP_W   (GROUP_W),
        .NUM_BANKS (NUM_BANKS)
    ) wbank_i (
        .clk      (clk),
        .rst      (rst),
        .pred_cnt (pred_cnt),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank)
    );

    // Registered grant outputs (R1, R8).
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_cnt <= '0;
            port_en   <= '0;
            port_slot <= '0;
            port_opnd <= '0;
        end else begin
            grant_cnt <= gcnt_c;
            port_en   <= pen_c;
            port_slot <= pslot_c;
            port_opnd <= popnd_c;
        end
    end

endmodule

// File: rtl/bank_rdport_arb_chk.sv
module bank_rdport_arb_chk #(
    parameter int GROUP_W   = 8,
    parameter int NUM_BANKS = 4,
    parameter int RD_PORTS  = 4,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int SW = $clog2(GROUP_W),
    localparam int CW = $clog2(GROUP_W + 1),
    localparam int NP = NUM_BANKS * RD_PORTS
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  first_valid,
    input logic [CW-1:0]         pred_cnt,
    input logic [CW-1:0]         grant_cnt,
    input logic [NP-1:0]         port_en,
    input logic [NP*SW-1:0]      port_slot,
    input logic [GROUP_W-1:0]    wr_en,
    input logic [GROUP_W*BW-1:0] wr_bank
);

    // R3
    grant_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(grant_cnt) <= GROUP_W);

    // R8
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !first_valid |=> grant_cnt == '0);

    for (genvar n = 0; n < NP; n++) begin : g_port
        // R5
        port_slot_granted_chk: assert property (@(posedge clk) disable iff (rst)
            port_en[n] |-> int'(port_slot[n*SW +: SW]) < int'(grant_cnt));
        if ((n % RD_PORTS) != 0) begin : g_thermo
            // R7
            port_contig_chk: assert property (@(posedge clk) disable iff (rst)
                port_en[n] |-> port_en[n-1]);
        end
    end

    for (genvar j = 1; j < GROUP_W; j++) begin : g_wr
        // R9
        wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en[j] |-> wr_en[j-1]);
        // R10
        wr_consec_chk: assert property (@(posedge clk) disable iff (rst)
            wr_bank[j*BW +: BW] == wr_bank[BW-1:0] + BW'(j));
    end

    // R9
    wr_count_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
        $countones(wr_en) == ((int'($past(pred_cnt)) > GROUP_W) ? GROUP_W : int'($past(pred_cnt))));

    // R10
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
        wr_bank[BW-1:0] == $past(wr_bank[BW-1:0]) + BW'($countones($past(wr_en))));

endmodule

bind bank_rdport_arb bank_rdport_arb_chk #(
    .GROUP_W   (GROUP_W),
    .NUM_BANKS (NUM_BANKS),
    .RD_PORTS  (RD_PORTS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .first_valid (slot_valid[0]),
    .pred_cnt    (pred_cnt),
    .grant_cnt   (grant_cnt),
    .port_en     (port_en),
    .port_slot   (port_slot),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank)
);

// File: tb/bank_rdport_arb_tb_top.sv
`timescale 1ns/1ps
module bank_rdport_arb_tb_top;

    localparam int G  = 8;
    localparam int NB = 4;
    localparam int PP = 4;
    localparam int BW = 2;
    localparam int SW = 3;
    localparam int CW = 4;
    localparam int NP = NB * PP;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst;
    logic [G-1:0]     slot_valid;
    logic [2*G-1:0]   slot_kind;
    logic [G*BW-1:0]  slot_src0_bank, slot_src1_bank, slot_dst_bank;
    logic [CW-1:0]    pred_cnt;
    logic [CW-1:0]    grant_cnt;
    logic [NP-1:0]    port_en;
    logic [NP*SW-1:0] port_slot;
    logic [NP*2-1:0]  port_opnd;
    logic [G-1:0]     wr_en;
    logic [G*BW-1:0]  wr_bank;

    bank_rdport_arb #(.GROUP_W(G), .NUM_BANKS(NB), .RD_PORTS(PP)) dut_i (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_kind(slot_kind),
        .slot_src0_bank(slot_src0_bank), .slot_src1_bank(slot_src1_bank),
        .slot_dst_bank(slot_dst_bank), .pred_cnt(pred_cnt), .grant_cnt(grant_cnt),
        .port_en(port_en), .port_slot(port_slot), .port_opnd(port_opnd),
        .wr_en(wr_en), .wr_bank(wr_bank)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Stimulus arrays
    bit v  [G];
    int kd [G];
    int s0 [G];
    int s1 [G];
    int dd [G];
    int pc;

    // Expected values
    int               exp_g;
    int               exp_nports;
    logic [NP-1:0]    exp_en;
    logic [NP*SW-1:0] exp_slot;
    logic [NP*2-1:0]  exp_opnd;
    logic [G-1:0]     exp_wren;
    logic [G*BW-1:0]  exp_wbank;
    int               exp_ptr = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < G; i++) begin
            v[i] = 1'b0; kd[i] = 0; s0[i] = 0; s1[i] = 0; dd[i] = 0;
        end
        pc = 0;
    endtask

    // Reference model from the requirements (R2..R7, R9, R10).
    task automatic model();
        int  used [NB];
        bit  stop;
        int  nd [NB];
        int  ob [3];
        bit  ou [3];
        int  pcc;
        for (int b = 0; b < NB; b++) used[b] = 0;
        stop = 1'b0;
        exp_g = 0; exp_nports = 0;
        exp_en = '0; exp_slot = '0; exp_opnd = '0;
        for (int i = 0; i < G; i++) begin
            bit fit;
            ou[0] = (kd[i] & 2) != 0; ou[1] = ou[0]; ou[2] = (kd[i] & 1) != 0;
            ob[0] = s0[i]; ob[1] = s1[i]; ob[2] = dd[i];
            for (int b = 0; b < NB; b++) nd[b] = 0;
            for (int k = 0; k < 3; k++) if (ou[k]) nd[ob[k]]++;
            fit = 1'b1;
            for (int b = 0; b < NB; b++) if (used[b] + nd[b] > PP) fit = 1'b0;
            if (stop || !v[i] || !fit) begin
                stop = 1'b1;
            end else begin
                for (int k = 0; k < 3; k++) begin
                    if (ou[k]) begin
                        int n;
                        n = ob[k] * PP + used[ob[k]];
                        exp_en[n] = 1'b1;
                        exp_slot[n*SW +: SW] = SW'(i);
                        exp_opnd[n*2 +: 2] = 2'(k);
                        used[ob[k]]++;
                        exp_nports++;
                    end
                end
                exp_g++;
            end
        end
        pcc = (pc > G) ? G : pc;
        for (int j = 0; j < G; j++) begin
            exp_wren[j] = (j < pcc);
            exp_wbank[j*BW +: BW] = BW'((exp_ptr + j) % NB);
        end
        exp_ptr = (exp_ptr + pcc) % NB;
    endtask

    // Drive at a falling edge, check one rising edge later at the next falling edge.
    task automatic run(string tag);
        int prev_g;
        logic [NP*SW-1:0] act_slot;
        logic [NP*2-1:0]  act_opnd;
        prev_g = exp_g;
        for (int i = 0; i < G; i++) begin
            slot_valid[i] = v[i];
            slot_kind[2*i +: 2] = 2'(kd[i]);
            slot_src0_bank[i*BW +: BW] = BW'(s0[i]);
            slot_src1_bank[i*BW +: BW] = BW'(s1[i]);
            slot_dst_bank[i*BW +: BW]  = BW'(dd[i]);
        end
        pred_cnt = CW'(pc);
        model();
        #1;
        chk("R8", "grant_cnt before edge", 64'(grant_cnt), 64'(prev_g));
        @(negedge clk);
        chk(tag, "grant_cnt", 64'(grant_cnt), 64'(exp_g));
        chk("R5", "port_en", 64'(port_en), 64'(exp_en));
        act_slot = '0; act_opnd = '0;
        for (int n = 0; n < NP; n++) begin
            if (port_en[n]) begin
                act_slot[n*SW +: SW] = port_slot[n*SW +: SW];
                act_opnd[n*2 +: 2]   = port_opnd[n*2 +: 2];
            end
        end
        chk("R5", "port_slot", 64'(act_slot), 64'(exp_slot));
        chk("R5", "port_opnd", 64'(act_opnd), 64'(exp_opnd));
        chk("R7", "enabled port count", 64'($countones(port_en)), 64'(exp_nports));
        chk("R9", "wr_en", 64'(wr_en), 64'(exp_wren));
        chk("R10", "wr_bank", 64'(wr_bank), 64'(exp_wbank));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1'b1;
        slot_valid = '0; slot_kind = '0; slot_src0_bank = '0;
        slot_src1_bank = '0; slot_dst_bank = '0; pred_cnt = '0;
        clear_slots();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "grant_cnt", 64'(grant_cnt), 64'd0);
        chk("R1", "port_en", 64'(port_en), 64'd0);
        chk("R1", "wr_en", 64'(wr_en), 64'd0);
        exp_g = 0;

        // R1/R10: first prediction after reset goes to bank 0
        clear_slots(); pc = 1;
        run("R1");
        chk("R1", "first wr bank", 64'(wr_bank[BW-1:0]), 64'd0);

        // R11: kind 0 slots consume no ports
        clear_slots();
        for (int i = 0; i < G; i++) v[i] = 1'b1;
        pc = 3;
        run("R11");
        chk("R11", "no ports used", 64'(port_en), 64'd0);

        // R2: validate-only reads destination bank once
        clear_slots(); v[0] = 1'b1; kd[0] = 1; dd[0] = 2; s0[0] = 3; s1[0] = 3;
        run("R2");
        chk("R2", "dst bank port", 64'(port_en), 64'(1 << (2*PP)));

        // R6: both sources in one bank take two ports
        clear_slots(); v[0] = 1'b1; kd[0] = 2; s0[0] = 1; s1[0] = 1;
        run("R6");
        chk("R6", "two ports bank1", 64'(port_en[PP +: PP]), 64'(4'b0011));

        // R4: overflow stops grant though a younger slot fits
        clear_slots();
        for (int i = 0; i < 4; i++) v[i] = 1'b1;
        kd[0] = 3; kd[1] = 1; kd[2] = 2; kd[3] = 1; dd[3] = 3;
        pc = 8;
        run("R4");
        chk("R4", "stopped at slot 2", 64'(grant_cnt), 64'd2);

        // R3: invalid slot ends the prefix
        clear_slots(); v[0] = 1'b1; v[1] = 1'b1; v[3] = 1'b1; pc = 5;
        run("R3");

        // R9: count above group width clamps
        clear_slots(); pc = 15;
        run("R9");

        // Full group, heavy demand
        clear_slots();
        for (int i = 0; i < G; i++) begin
            v[i] = 1'b1; kd[i] = 3; s0[i] = i % NB; s1[i] = (i + 1) % NB; dd[i] = (i + 2) % NB;
        end
        run("R3");

        // Constrained random
        for (int c = 0; c < 600; c++) begin
            int len;
            clear_slots();
            len = $urandom_range(0, G);
            for (int i = 0; i < G; i++) begin
                v[i]  = (i < len) || ($urandom_range(0, 7) == 0);
                kd[i] = $urandom_range(0, 3);
                s0[i] = $urandom_range(0, NB-1);
                s1[i] = $urandom_range(0, NB-1);
                dd[i] = $urandom_range(0, NB-1);
            end
            pc = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : $urandom_range(0, G);
            run("R3");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule